// File: doc/BRIEF.md
# Voted Clock Branch Gate

This block gates one branch clock that comes from a free-running source clock. Two requests can turn the branch on. The first is a local enable bit in the branch control register. The second is this branch's own bit in a 32-bit vote register, which many branches share. The effective request is the OR of the two. It crosses into the source-clock domain through a synchronizer and then drives a latch-based gate, so the output only ever carries whole clock pulses.

The gate state is synchronized back into the register-clock domain and appears as a read-only "stopped" flag in the control register. Software sets either request, then polls that flag until it reads 0 before it relies on the clock. A third register holds one bit that drives the reset line of the downstream block. The register interface is a simple single-cycle write port and a read port with one cycle of latency.

Top module: `cbg_branch_gate`

## Requirements
- R1: After reset, the control register (address 0) reads 0x8000_0000, the vote register (address 1) reads 0, the block-reset register (address 2) reads 0, `blk_rst` is 0, and `clk_gated` shows no pulses.
- R2: Writing 1 to bit 0 of the control register (the local enable) starts pulses on `clk_gated`. Writing 0 there, with the vote bit clear, stops them.
- R3: Bit `VOTE_BIT` (default 10) of the vote register starts the branch clock when the local enable is 0. The branch runs whenever the local enable or the vote bit is 1.
- R4: Vote-register bits other than `VOTE_BIT` have no effect on the branch. All 32 bits are stored and read back as written.
- R5: Bit 31 of the control register reads 1 while the branch clock is stopped and 0 while it runs. Writes to bit 31 are ignored. Bits 30..1 read 0.
- R6: The stopped flag still reads its old value on the read issued in the cycle right after the request changes. It reaches the new value within 16 register-clock cycles.
- R7: Every high pulse on `clk_gated` lasts exactly one high phase of `clk_src`. Once the gate is closed, `clk_gated` stays low.
- R8: `blk_rst` equals bit 0 of the block-reset register. It changes one register-clock cycle after the write.
- R9: Read data appears one cycle after `bus_rd`. Address 3 reads 0, and writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset, register domain |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| clk_src | input | 1 | Free-running source clock of the branch |
| clk_gated | output | 1 | Gated branch clock |
| blk_rst | output | 1 | Reset line to the downstream block |

## Verification
Suppose the enable synchronizer or the latch holds a wrong value. The stopped flag then disagrees with the OR of the two requests, and a poll loop either never finishes or finishes at once, within a few cycles of the write. A latch that passes its input during the high phase shows up as a `clk_gated` pulse shorter than half a source period, on the first toggle of the request. A faulty vote decode shows up when other vote bits are set while the branch flag stays unchanged.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_VOTE = 2'd1,
    ADR_BRST = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_OFF_BIT = 31;
  localparam int unsigned BRST_BIT     = 0;
endpackage

// File: rtl/cbg_sync.sv
module cbg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= {STAGES{RST_VAL}};
    else     stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cbg_regs.sv
module cbg_regs
  import cbg_pkg::*;
#(
  parameter int unsigned VOTE_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              off_i,
  output logic              req_o,
  output logic              brst_o
);
  logic             en_q, en_d;
  logic [REG_W-1:0] vote_q, vote_d;
  logic             brst_q, brst_d;
  logic             req_q;
  logic [REG_W-1:0] rdata_q;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(bus_addr);

  always_comb begin
    en_d   = en_q;
    vote_d = vote_q;
    brst_d = brst_q;
    if (bus_wr) begin
      case (addr)
        ADR_CTRL: en_d   = bus_wdata[CTRL_EN_BIT];
        ADR_VOTE: vote_d = bus_wdata;
        ADR_BRST: brst_d = bus_wdata[BRST_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      vote_q <= '0;
      brst_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      vote_q <= vote_d;
      brst_q <= brst_d;
      // registered OR so the crossing sees a glitch-free source
      req_q  <= en_d | vote_d[VOTE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= '0;
      case (addr)
        ADR_CTRL: begin
          rdata_q[CTRL_EN_BIT]  <= en_q;
          rdata_q[CTRL_OFF_BIT] <= off_i;
        end
        ADR_VOTE: rdata_q <= vote_q;
        ADR_BRST: rdata_q[BRST_BIT] <= brst_q;
        default:  ;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign req_o     = req_q;
  assign brst_o    = brst_q;

  AST_OFF_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0) |=> bus_rdata[CTRL_OFF_BIT] == $past(off_i)); // R5
  AST_BRST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2) |=> brst_o == $past(bus_wdata[BRST_BIT])); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata == '0); // R9
endmodule

// File: rtl/cbg_gate.sv
module cbg_gate (
  input  logic clk_src,
  input  logic rst,
  input  logic en_i,
  output logic clk_o,
  output logic on_o
);
  logic en_lat;
  logic on_q;

  // transparent only while the source is low: the enable settles before a rising edge
  always_latch begin
    if (!clk_src) en_lat = en_i;
  end

  always_ff @(posedge clk_src) begin
    if (rst) on_q <= 1'b0;
    else     on_q <= en_lat;
  end

  assign clk_o = clk_src & en_lat;
  assign on_o  = on_q;

  AST_GATE_HELD: assert property (@(negedge clk_src) disable iff (rst)
    en_lat == on_q); // R7
endmodule

// File: rtl/cbg_branch_gate.sv
module cbg_branch_gate
  import cbg_pkg::*;
#(
  parameter int unsigned VOTE_BIT    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              clk_src,
  output logic              clk_gated,
  output logic              blk_rst
);
  logic [SYNC_STAGES-1:0] src_rst_q;
  logic                   src_rst;
  logic                   req;
  logic                   req_src;
  logic                   gate_on;
  logic                   gate_on_reg;
  logic                   off_flag;

  // reset carried into the source domain
  always_ff @(posedge clk_src) src_rst_q <= {src_rst_q[SYNC_STAGES-2:0], rst};
  assign src_rst = src_rst_q[SYNC_STAGES-1];

  cbg_regs #(.VOTE_BIT(VOTE_BIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .off_i     (off_flag),
    .req_o     (req),
    .brst_o    (blk_rst)
  );

  cbg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_fwd (
    .clk (clk_src),
    .rst (src_rst),
    .d   (req),
    .q   (req_src)
  );

  cbg_gate u_gate (
    .clk_src (clk_src),
    .rst     (src_rst),
    .en_i    (req_src),
    .clk_o   (clk_gated),
    .on_o    (gate_on)
  );

  cbg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_back (
    .clk (clk),
    .rst (rst),
    .d   (gate_on),
    .q   (gate_on_reg)
  );

  assign off_flag = ~gate_on_reg;

  AST_OFF_LAGS_REQ: assert property (@(posedge clk) disable iff (rst)
    (off_flag && $rose(req)) |=> off_flag); // R6
endmodule

// File: tb/cbg_branch_gate_tb.sv
`timescale 1ns/1ps
module cbg_branch_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SRC_HALF   = 7;
  localparam int VOTE_BIT   = 10;

  logic        clk = 0, clk_src = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        clk_gated, blk_rst;

  int errors = 0, checks = 0;
  int pulses = 0, glitches = 0;
  time t_rise = 0;
  bit  seen_rise = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SRC_HALF) clk_src = ~clk_src;

  cbg_branch_gate #(.VOTE_BIT(VOTE_BIT)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_src(clk_src),
    .clk_gated(clk_gated), .blk_rst(blk_rst)
  );

  always @(posedge clk_gated) begin
    t_rise = $time; seen_rise = 1; pulses++;
  end
  always @(negedge clk_gated) begin
    if (seen_rise && ($time - t_rise) != SRC_HALF) glitches++;
  end

  function automatic bit exp_off(bit en, logic [31:0] vote);
    return !(en | vote[VOTE_BIT]);
  endfunction

  function automatic logic [31:0] exp_ctrl(bit en, logic [31:0] vote);
    return {exp_off(en, vote), 30'd0, en};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  // reads control until the stopped flag equals want; returns the read count
  task automatic poll(bit want, output int n, output logic [31:0] first);
    logic [31:0] d;
    n = 0;
    first = '0;
    for (int i = 0; i < 20; i++) begin
      rd(2'd0, d);
      if (i == 0) first = d;
      n++;
      if (d[31] == want) break;
    end
  endtask

  task automatic count_window(output int p);
    pulses = 0;
    repeat (12) @(negedge clk);
    p = pulses;
  endtask

  initial begin : main
    logic [31:0] d, first;
    int n, p;
    bit en;
    logic [31:0] vote;
    void'($urandom(32'h5EED));
    repeat (10) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check(d == 32'h8000_0000, "R1 ctrl", d, 32'h8000_0000);
    rd(2'd1, d); check(d == 0, "R1 vote", d, 0);
    rd(2'd2, d); check(d == 0, "R1 brst", d, 0);
    check(blk_rst == 0, "R1 blk_rst", blk_rst, 0);
    count_window(p); check(p == 0, "R1 no pulses", p, 0);

    // R2 + R6 local enable
    wr(2'd0, 32'h1);
    poll(0, n, first);
    check(first[31] == 1, "R6 flag lags", first[31], 1);
    check(n <= 16 && first[0] == 1, "R2 R6 on via local", n, 16);
    count_window(p); check(p > 0, "R2 pulses", p, 1);
    // R5 write to bit 31 ignored
    wr(2'd0, 32'h8000_0001);
    repeat (6) @(negedge clk);
    rd(2'd0, d); check(d == 32'h0000_0001, "R5 ro flag", d, 32'h1);
    wr(2'd0, 32'h0);
    poll(1, n, first);
    check(first[31] == 0 && n <= 16, "R2 R6 off", n, 16);
    count_window(p); check(p == 0, "R2 stopped", p, 0);

    // R3 vote path
    wr(2'd1, 32'h1 << VOTE_BIT);
    poll(0, n, first);
    check(first[31] == 1 && n <= 16, "R3 on via vote", n, 16);
    count_window(p); check(p > 0, "R3 pulses", p, 1);
    wr(2'd1, 32'h0);
    poll(1, n, first);
    check(n <= 16, "R3 off", n, 16);

    // R4 foreign vote bits
    wr(2'd1, ~(32'h1 << VOTE_BIT));
    repeat (16) @(negedge clk);
    rd(2'd0, d); check(d == 32'h8000_0000, "R4 no effect", d, 32'h8000_0000);
    count_window(p); check(p == 0, "R4 no pulses", p, 0);
    rd(2'd1, d); check(d == ~(32'h1 << VOTE_BIT), "R4 readback", d, ~(32'h1 << VOTE_BIT));

    // R8 block reset
    wr(2'd2, 32'h1);
    check(blk_rst == 1, "R8 assert", blk_rst, 1);
    rd(2'd2, d); check(d == 1, "R8 read", d, 1);
    wr(2'd2, 32'hFFFF_FFFE);
    check(blk_rst == 0, "R8 release", blk_rst, 0);

    // R9 unmapped
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); check(d == 0, "R9 reads zero", d, 0);
    rd(2'd0, d); check(d == 32'h8000_0000, "R9 ctrl kept", d, 32'h8000_0000);
    rd(2'd1, d); check(d == ~(32'h1 << VOTE_BIT), "R9 vote kept", d, ~(32'h1 << VOTE_BIT));
    check(blk_rst == 0, "R9 brst kept", blk_rst, 0);

    // R2 R3 R4 R5 random mix
    for (int it = 0; it < 40; it++) begin
      en = 1'($urandom);
      vote = $urandom;
      wr(2'd0, {1'($urandom), 30'd0, en});
      wr(2'd1, vote);
      poll(exp_off(en, vote), n, first);
      rd(2'd0, d);
      check(d == exp_ctrl(en, vote), "R3 R5 random ctrl", d, exp_ctrl(en, vote));
      rd(2'd1, d); check(d == vote, "R4 random vote", d, vote);
      count_window(p);
      check(exp_off(en, vote) ? (p == 0) : (p > 0), "R2 R3 random pulses", p,
            {31'd0, !exp_off(en, vote)});
    end

    // R7 no partial pulses across all toggles
    check(glitches == 0, "R7 whole pulses", glitches, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule